// File: doc/BRIEF.md
# Staged Audio Port Global Control

This block holds the global enable register of a multichannel audio serial port. Each of its two halves, receive and transmit, has five enables. Each enable lets one downstream sub-unit leave reset: the bit clock divider, the high-frequency clock divider, the serializer, the state machine and the frame sync generator. Software starts a half in stages, one bit per read-modify-write. The order is high-frequency clock, bit clock, serializer, state machine, then frame sync. After each step software polls until the bit it wrote reads back as set.

A readback bit does not reflect the stored enable. It reflects the acknowledge that the downstream domain returns for that enable, passed through a two-flop synchroniser. A set bit therefore means the stage has really started. The block also keeps sticky per-direction status bits that are cleared by writing ones, and a per-direction bit that blocks data DMA requests.

The register bus has a write strobe, a word address and write data. Read data is combinational from the address. The word addresses are:

| Address | Register |
|---|---|
| 0 | Combined enables for both halves |
| 1 | Receive-only alias |
| 2 | Transmit-only alias |
| 3 | Receive status |
| 4 | Transmit status |
| 5 | Receive DMA control |
| 6 | Transmit DMA control |

Any other address reads zero.

Top module: `audio_port_gctl`

## Requirements
- R1: After reset all enable outputs, all readback bits, all status bits and both DMA-disable bits are zero, and every address reads zero.
- R2: In the receive half, bit 0 is the bit clock divider, bit 1 the high-frequency clock divider, bit 2 the serializer, bit 3 the state machine and bit 4 the frame sync. A write to address 0 or 1 drives `rx_en[i]` from data bit i on the clock edge that takes the write.
- R3: The transmit half uses the same five functions, in the same order, at bits 8 to 12. A write to address 0 or 2 drives `tx_en[i]` from data bit 8+i on the clock edge that takes the write.
- R4: Readback bit i of a half (bit i for receive, bit 8+i for transmit, at address 0 or the half's alias) equals that half's acknowledge input i delayed by two clock edges.
- R5: A write that sets the state machine or frame sync bit of a half while the same write leaves that half's bit clock divider bit clear stores both of those bits as zero. They then neither drive the enable output nor read back as set.
- R6: A write to the receive alias (address 1) leaves the transmit enables unchanged, and a write to the transmit alias (address 2) leaves the receive enables unchanged. Each alias reads only its own half's bits, and all other bits read zero.
- R7: Status bits (addresses 3 and 4, bits 0 to 7) are set by pulses on the event inputs and stay set. Writing a one to a bit clears it. An event in the same cycle as the clear wins.
- R8: Bit 0 at address 5 (receive) or address 6 (transmit) blocks that half's data DMA request when set. The request output equals the request input ANDed with the inverse of that bit.
- R9: Writing zero to a half drops all of its enables on the next edge. Its readback clears two edges after the acknowledges fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rx_en | output | 5 | Receive sub-unit enables |
| tx_en | output | 5 | Transmit sub-unit enables |
| rx_ack | input | 5 | Receive-domain acknowledges |
| tx_ack | input | 5 | Transmit-domain acknowledges |
| rx_stat_set | input | 8 | Receive status event pulses |
| tx_stat_set | input | 8 | Transmit status event pulses |
| rx_dreq | input | 1 | Receive data DMA request in |
| tx_dreq | input | 1 | Transmit data DMA request in |
| rx_dma_req | output | 1 | Receive data DMA request out |
| tx_dma_req | output | 1 | Transmit data DMA request out |

## Verification
The assertions check every cycle that:
- no half ever has a state machine or frame sync enable without its clock divider enable;
- an alias write never disturbs the other half;
- status bits never drop without a clear write;
- a readback bit only rises two edges after its acknowledge;
- a blocked DMA request never passes.

The bench's scenarios show the staged start sequence, the exact two-edge readback lag, the write-one-to-clear race with a new event, and the stop of one half while the other keeps running. It drives these against a behavioural model compared on every clock.

// File: rtl/audio_port_gctl.sv
module audio_port_gctl #(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int NEN    = 5,
  parameter int TX_LO  = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NEN-1:0]    rx_en,
  output logic [NEN-1:0]    tx_en,
  input  logic [NEN-1:0]    rx_ack,
  input  logic [NEN-1:0]    tx_ack,
  input  logic [STAT_W-1:0] rx_stat_set,
  input  logic [STAT_W-1:0] tx_stat_set,
  input  logic              rx_dreq,
  input  logic              tx_dreq,
  output logic              rx_dma_req,
  output logic              tx_dma_req
);
  localparam logic [AW-1:0] A_ALL  = AW'(0);
  localparam logic [AW-1:0] A_RX   = AW'(1);
  localparam logic [AW-1:0] A_TX   = AW'(2);
  localparam logic [AW-1:0] A_RSTS = AW'(3);
  localparam logic [AW-1:0] A_TSTS = AW'(4);
  localparam logic [AW-1:0] A_RDMA = AW'(5);
  localparam logic [AW-1:0] A_TDMA = AW'(6);
  localparam int B_CLK = 0;
  localparam int B_SM  = 3;
  localparam int B_FS  = 4;

  logic [NEN-1:0]    rx_s1, rx_rb, tx_s1, tx_rb;
  logic [STAT_W-1:0] rx_sts, tx_sts;
  logic              rx_dis, tx_dis;
  logic              unused_wbits;

  function automatic logic [NEN-1:0] gate_en(input logic [NEN-1:0] v);
    gate_en = v;
    if (!v[B_CLK]) begin
      gate_en[B_SM] = 1'b0;
      gate_en[B_FS] = 1'b0;
    end
  endfunction

  wire wr_rx  = bus_wr && (bus_addr == A_ALL || bus_addr == A_RX);
  wire wr_tx  = bus_wr && (bus_addr == A_ALL || bus_addr == A_TX);
  wire clr_rs = bus_wr && bus_addr == A_RSTS;
  wire clr_ts = bus_wr && bus_addr == A_TSTS;

  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= '0;
      tx_en  <= '0;
      rx_s1  <= '0;
      rx_rb  <= '0;
      tx_s1  <= '0;
      tx_rb  <= '0;
      rx_sts <= '0;
      tx_sts <= '0;
      rx_dis <= 1'b0;
      tx_dis <= 1'b0;
    end else begin
      if (wr_rx) rx_en <= gate_en(bus_wdata[NEN-1:0]);
      if (wr_tx) tx_en <= gate_en(bus_wdata[TX_LO +: NEN]);
      rx_s1  <= rx_ack;
      rx_rb  <= rx_s1;
      tx_s1  <= tx_ack;
      tx_rb  <= tx_s1;
      rx_sts <= (rx_sts & ~(clr_rs ? bus_wdata[STAT_W-1:0] : '0)) | rx_stat_set;
      tx_sts <= (tx_sts & ~(clr_ts ? bus_wdata[STAT_W-1:0] : '0)) | tx_stat_set;
      if (bus_wr && bus_addr == A_RDMA) rx_dis <= bus_wdata[0];
      if (bus_wr && bus_addr == A_TDMA) tx_dis <= bus_wdata[0];
    end
  end

  assign rx_dma_req = rx_dreq & ~rx_dis;
  assign tx_dma_req = tx_dreq & ~tx_dis;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ALL: begin
        bus_rdata[NEN-1:0]     = rx_rb;
        bus_rdata[TX_LO +: NEN] = tx_rb;
      end
      A_RX:   bus_rdata[NEN-1:0]     = rx_rb;
      A_TX:   bus_rdata[TX_LO +: NEN] = tx_rb;
      A_RSTS: bus_rdata[STAT_W-1:0]  = rx_sts;
      A_TSTS: bus_rdata[STAT_W-1:0]  = tx_sts;
      A_RDMA: bus_rdata[0]           = rx_dis;
      A_TDMA: bus_rdata[0]           = tx_dis;
      default: bus_rdata = '0;
    endcase
  end

  AST_RX_STAGE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en[B_SM] || rx_en[B_FS]) |-> rx_en[B_CLK]) else $error("rx gate"); // R5
  AST_TX_STAGE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en[B_SM] || tx_en[B_FS]) |-> tx_en[B_CLK]) else $error("tx gate"); // R5
  AST_RX_ALIAS_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_RX) |=> $stable(tx_en)) else $error("rx alias"); // R6
  AST_TX_ALIAS_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TX) |=> $stable(rx_en)) else $error("tx alias"); // R6
  AST_READBACK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_rb[B_CLK]) |-> $past(rx_ack[B_CLK], 2)) else $error("rb lag"); // R4
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_RSTS) |=> (($past(rx_sts) & ~rx_sts) == '0)) else $error("sticky"); // R7
  AST_DMA_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[0] && bus_addr == A_TDMA) |-> !tx_dma_req) else $error("dma"); // R8
endmodule

// File: tb/tb_audio_port_gctl.sv
`timescale 1ns/1ps
module tb_audio_port_gctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  rx_en, tx_en, rx_ack, tx_ack;
  logic [7:0]  rx_stat_set = '0, tx_stat_set = '0;
  logic        rx_dreq = 1'b0, tx_dreq = 1'b0, rx_dma_req, tx_dma_req;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign rx_ack = rx_en;
  assign tx_ack = tx_en;

  audio_port_gctl dut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .rx_en, .tx_en, .rx_ack, .tx_ack, .rx_stat_set, .tx_stat_set,
    .rx_dreq, .tx_dreq, .rx_dma_req, .tx_dma_req);

  logic [4:0] m_rxen = '0, m_txen = '0, m_rx1 = '0, m_rx2 = '0, m_tx1 = '0, m_tx2 = '0;
  logic [7:0] m_rsts = '0, m_tsts = '0;
  logic       m_rdis = 1'b0, m_tdis = 1'b0;

  function automatic logic [4:0] stage_rule(input logic [4:0] v);
    stage_rule = v;
    if (!v[0]) stage_rule = v & 5'b00111;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rxen = '0; m_txen = '0; m_rx1 = '0; m_rx2 = '0; m_tx1 = '0; m_tx2 = '0;
      m_rsts = '0; m_tsts = '0; m_rdis = 0; m_tdis = 0;
    end else begin
      m_rx2 = m_rx1; m_rx1 = m_rxen;
      m_tx2 = m_tx1; m_tx1 = m_txen;
      if (bus_wr) begin
        if (bus_addr == 0 || bus_addr == 1) m_rxen = stage_rule(bus_wdata[4:0]);
        if (bus_addr == 0 || bus_addr == 2) m_txen = stage_rule(bus_wdata[12:8]);
        if (bus_addr == 3) m_rsts = m_rsts & ~bus_wdata[7:0];
        if (bus_addr == 4) m_tsts = m_tsts & ~bus_wdata[7:0];
        if (bus_addr == 5) m_rdis = bus_wdata[0];
        if (bus_addr == 6) m_tdis = bus_wdata[0];
      end
      m_rsts = m_rsts | rx_stat_set;
      m_tsts = m_tsts | tx_stat_set;
    end
  end

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    model_rd = '0;
    case (a)
      3'd0: begin model_rd[4:0] = m_rx2; model_rd[12:8] = m_tx2; end
      3'd1: model_rd[4:0] = m_rx2;
      3'd2: model_rd[12:8] = m_tx2;
      3'd3: model_rd[7:0] = m_rsts;
      3'd4: model_rd[7:0] = m_tsts;
      3'd5: model_rd[0] = m_rdis;
      3'd6: model_rd[0] = m_tdis;
      default: model_rd = '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check("R2_R3 enable outputs", {22'd0, rx_en, tx_en}, {22'd0, m_rxen, m_txen});
    check("R4_R6_R7 read data", bus_rdata, model_rd(bus_addr));
    check("R8 dma requests", {30'd0, rx_dma_req, tx_dma_req},
          {30'd0, rx_dreq & ~m_rdis, tx_dreq & ~m_tdis});
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(); bus_wr = 1; bus_addr = a; bus_wdata = d;
    step(); bus_wr = 0;
  endtask
  task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a; #1; check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    for (int a = 0; a < 8; a++) rd("R1 reset read", 3'(a), 32'd0);
    check("R1 reset enables", {22'd0, rx_en, tx_en}, 32'd0);
    rst_n = 1;
    step();
    // staged receive start: hf, clk, ser, sm, fs
    wr(3'd1, 32'h02);
    rd("R4 lag edge0", 3'd1, 32'h00);
    check("R2 hf enable", {27'd0, rx_en}, 32'h02);
    step(); rd("R4 lag edge1", 3'd1, 32'h00);
    step(); rd("R4 lag edge2", 3'd1, 32'h02);
    wr(3'd1, 32'h03); step(); step();
    wr(3'd1, 32'h07); step(); step();
    wr(3'd1, 32'h0F); step(); step();
    wr(3'd1, 32'h1F); step(); step();
    rd("R2 rx all stages", 3'd1, 32'h1F);
    rd("R6 combined view", 3'd0, 32'h1F);
    // transmit via alias with gating violation
    wr(3'd2, 32'h1A00); step(); step();
    check("R5 tx gated", {27'd0, tx_en}, 32'h02);
    rd("R5 tx gated readback", 3'd2, 32'h0200);
    check("R6 rx untouched", {27'd0, rx_en}, 32'h1F);
    wr(3'd2, 32'h1F00); step(); step();
    rd("R3 tx all stages", 3'd0, 32'h1F1F);
    // stop receive only
    wr(3'd1, 32'h0);
    check("R9 rx dropped", {22'd0, rx_en, tx_en}, {22'd0, 5'h00, 5'h1F});
    rd("R9 readback still set", 3'd1, 32'h1F);
    step(); step();
    rd("R9 readback cleared", 3'd0, 32'h1F00);
    // combined write gating on rx
    wr(3'd0, 32'h0418); step(); step();
    rd("R5 R3 combined", 3'd0, 32'h0400);
    // status
    step(); rx_stat_set = 8'hA5; tx_stat_set = 8'h3C;
    step(); rx_stat_set = 0; tx_stat_set = 0;
    rd("R7 rx sticky", 3'd3, 32'hA5);
    rd("R7 tx sticky", 3'd4, 32'h3C);
    step(); bus_wr = 1; bus_addr = 3'd3; bus_wdata = 32'h85; rx_stat_set = 8'h80;
    step(); bus_wr = 0; rx_stat_set = 0;
    rd("R7 w1c event wins", 3'd3, 32'hA0);
    wr(3'd4, 32'hFF); rd("R7 tx cleared", 3'd4, 32'h0);
    // dma
    rx_dreq = 1; tx_dreq = 1; #1;
    check("R8 pass", {30'd0, rx_dma_req, tx_dma_req}, 32'd3);
    wr(3'd5, 32'h1); #1;
    check("R8 rx blocked", {30'd0, rx_dma_req, tx_dma_req}, 32'd1);
    wr(3'd6, 32'h1); #1;
    check("R8 tx blocked", {30'd0, rx_dma_req, tx_dma_req}, 32'd0);
    rd("R8 rx dis read", 3'd5, 32'h1);
    wr(3'd5, 32'h0); #1;
    check("R8 rx released", {30'd0, rx_dma_req, tx_dma_req}, 32'd2);
    rd("R1 unmapped", 3'd7, 32'h0);
    repeat (4) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule